// File: doc/BRIEF.md
# Edge/Level Interrupt Flag Cell

This cell turns an asynchronous, active-low interrupt request pin into a single interrupt flag bit that the processor core reads and services. The pin is first resynchronised to the core clock. It then feeds either a level detector, which sets the flag in every cycle the pin is low, or a falling-edge detector. The edge detector compares the synchronised pin with a one-cycle delayed copy and sets the flag once per high-to-low transition.

A stored mode bit selects between the two detectors. It is written through a write strobe with a data bit. Reset clears the flag and forces the effective mode to level, whatever the stored mode bit holds. This lets a pin that is held low during boot be seen. The override lasts until software first writes the mode bit. The core also has a set strobe and a clear strobe for the flag. A set from any source wins over a clear in the same cycle, so no request is lost. During reset the synchroniser and the delay line load the live pin level. A pin held low through reset therefore gives no false edge later.

Top module: `irq_flag_cell`

## Requirements
- R1: While `rst_n` is low, `flag` is 0 from the next rising edge on, and it is still 0 when reset is released with the pin high.
- R2: After reset, `edge_active` is 0 even when the stored mode is edge (reset value 1), until the first `mode_we` pulse. From the edge after a write, `edge_active` equals the written `mode_wdata` bit (1 = edge, 0 = level).
- R3: In level mode, a low pin sets `flag` SYNC_STAGES+1 rising edges after the pin falls. It keeps setting it on every edge while the pin stays low, so a clear has no lasting effect.
- R4: In edge mode, a high-to-low transition of the pin sets `flag` SYNC_STAGES+1 edges later. This holds when the pin stays high and then low for at least two cycles each. The transition sets the flag only once: after a clear, a pin that stays low does not set it again.
- R5: If a set (from the pin or from `cpu_set`) and `cpu_clr` occur in the same cycle, `flag` is 1 after that edge.
- R6: `cpu_clr` with no set pending makes `flag` 0 at the next edge. With no strobe and no pin set, `flag` holds its value.
- R7: `cpu_set` makes `flag` 1 at the next edge, whatever the pin and the mode.
- R8: A pin held low through reset and then through a switch to edge mode gives no edge set: once cleared, `flag` stays 0.
- R9: In edge mode, a low-to-high transition of the pin does not set `flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n | input | 1 | Asynchronous active-low interrupt pin |
| mode_we | input | 1 | Write strobe for the mode bit |
| mode_wdata | input | 1 | Mode value to write: 1 edge, 0 level |
| cpu_set | input | 1 | Core strobe that forces the flag to 1 |
| cpu_clr | input | 1 | Core strobe that clears the flag |
| flag | output | 1 | Interrupt flag |
| edge_active | output | 1 | Effective mode: 1 when edge detection is in force |

## Verification
Every pin-driven result appears SYNC_STAGES+1 rising edges after the pin changes: one edge to enter the synchroniser (SYNC_STAGES in total) and one more to register the flag. With the default single stage this is two edges. Strobe results (`cpu_set`, `cpu_clr`, `mode_we`) appear after exactly one edge. The bench drives all inputs on the falling edge and samples 1 ns after the rising edge. It checks pin results one edge before they are due (still old value) and again on the edge they are due, so a wrong latency shows up as a mismatch.

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
  parameter int  SYNC_STAGES = 1,
  parameter bit  MODE_RST    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic mode_we,
  input  logic mode_wdata,
  input  logic cpu_set,
  input  logic cpu_clr,
  output logic flag,
  output logic edge_active
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          dly_q;
  logic          mode_q;
  logic          boot_q;
  logic          pin_lvl;
  logic          edge_pulse;
  logic          pin_set;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) sync_q <= irq_n;
    end else begin : g_chain
      always_ff @(posedge clk)
        if (!rst_n) sync_q <= {SYNC_STAGES{irq_n}};
        else        sync_q <= {sync_q[LAST-1:0], irq_n};
    end
  endgenerate

  always_ff @(posedge clk)
    if (!rst_n) dly_q <= irq_n;
    else        dly_q <= sync_q[LAST];

  always_ff @(posedge clk)
    if (!rst_n) begin
      mode_q <= MODE_RST;
      boot_q <= 1'b1;
    end else if (mode_we) begin
      mode_q <= mode_wdata;
      boot_q <= 1'b0;
    end

  assign edge_active = mode_q & ~boot_q;
  assign pin_lvl     = ~sync_q[LAST];
  assign edge_pulse  = dly_q & ~sync_q[LAST];
  assign pin_set     = edge_active ? edge_pulse : pin_lvl;

  always_ff @(posedge clk)
    if (!rst_n)                 flag <= 1'b0;
    else if (pin_set | cpu_set) flag <= 1'b1;
    else if (cpu_clr)           flag <= 1'b0;

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !flag); // R1
  AST_BOOT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !edge_active); // R2
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> edge_active == $past(mode_wdata)); // R2
  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_active && !sync_q[LAST]) |=> flag); // R3
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_set && cpu_clr) |=> flag); // R5
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clr && !cpu_set && !pin_set) |=> !flag); // R6
  AST_CPU_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_set |=> flag); // R7

endmodule

// File: tb/test_irq_flag_cell.sv
module test_irq_flag_cell;
  logic clk = 1'b0;
  logic rst_n, irq_n, mode_we, mode_wdata, cpu_set, cpu_clr;
  logic flag, edge_active;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  irq_flag_cell i_irq_flag_cell (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .cpu_set(cpu_set), .cpu_clr(cpu_clr),
    .flag(flag), .edge_active(edge_active)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic write_mode(input logic m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    tick(1);
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic strobe(input logic s, input logic c);
    @(negedge clk); cpu_set = s; cpu_clr = c;
    tick(1);
    @(negedge clk); cpu_set = 1'b0; cpu_clr = 1'b0;
  endtask

  task automatic pin(input logic v);
    @(negedge clk); irq_n = v;
  endtask

  task automatic t_reset_boot;
    rst_n = 1'b0; irq_n = 1'b0; mode_we = 1'b0; mode_wdata = 1'b0;
    cpu_set = 1'b0; cpu_clr = 1'b0;
    tick(3);
    chk("R1 flag in reset", flag, 1'b0);
    chk("R2 edge_active in reset", edge_active, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    tick(1);
    chk("R3 held-low pin seen after boot", flag, 1'b1);
    chk("R2 override after release", edge_active, 1'b0);
  endtask

  task automatic t_level_clear_loses;
    strobe(1'b0, 1'b1);
    chk("R5 level set beats clear", flag, 1'b1);
  endtask

  task automatic t_switch_no_false_edge;
    write_mode(1'b1);
    chk("R2 write edge mode", edge_active, 1'b1);
    strobe(1'b0, 1'b1);
    chk("R6 clear", flag, 1'b0);
    tick(5);
    chk("R8 no edge from held-low pin", flag, 1'b0);
  endtask

  task automatic t_edge_detect;
    pin(1'b1);
    tick(4);
    chk("R9 rising edge ignored", flag, 1'b0);
    pin(1'b0);
    tick(1);
    chk("R4 not yet after one edge", flag, 1'b0);
    tick(1);
    chk("R4 falling edge sets", flag, 1'b1);
    strobe(1'b0, 1'b1);
    chk("R6 clear in edge mode", flag, 1'b0);
    tick(4);
    chk("R4 held low sets only once", flag, 1'b0);
    pin(1'b1); tick(2);
    pin(1'b0); tick(2);
    chk("R4 two-cycle pulse detected", flag, 1'b1);
    @(negedge clk); irq_n = 1'b1; cpu_clr = 1'b1;
    tick(1);
    @(negedge clk); cpu_clr = 1'b0;
    tick(3);
    chk("R9 rising edge ignored after clear", flag, 1'b0);
  endtask

  task automatic t_cpu_strobes;
    strobe(1'b1, 1'b1);
    chk("R5 cpu set beats clear", flag, 1'b1);
    strobe(1'b0, 1'b1);
    chk("R6 clear", flag, 1'b0);
    strobe(1'b1, 1'b0);
    chk("R7 cpu set", flag, 1'b1);
    tick(3);
    chk("R6 flag holds", flag, 1'b1);
    strobe(1'b0, 1'b1);
  endtask

  task automatic t_level_mode;
    write_mode(1'b0);
    chk("R2 write level mode", edge_active, 1'b0);
    tick(3);
    chk("R6 flag holds at 0", flag, 1'b0);
    pin(1'b0);
    tick(1);
    chk("R3 not yet after one edge", flag, 1'b0);
    tick(1);
    chk("R3 low pin sets", flag, 1'b1);
    strobe(1'b0, 1'b1);
    tick(1);
    chk("R3 re-set while low", flag, 1'b1);
    pin(1'b1);
    tick(2);
    strobe(1'b0, 1'b1);
    chk("R6 clear after pin high", flag, 1'b0);
  endtask

  task automatic t_reset_again;
    write_mode(1'b1);
    @(negedge clk); rst_n = 1'b0;
    tick(2);
    chk("R1 reset clears", flag, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    tick(2);
    chk("R1 flag 0 after release pin high", flag, 1'b0);
    chk("R2 override after second reset", edge_active, 1'b0);
    pin(1'b0);
    tick(2);
    chk("R2 level detection until write", flag, 1'b1);
  endtask

  initial begin
    t_reset_boot();
    t_level_clear_loses();
    t_switch_no_false_edge();
    t_edge_detect();
    t_cpu_strobes();
    t_level_mode();
    t_reset_again();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule